// File: doc/BRIEF.md
# Directory Eviction Invalidation Sequencer

When a coherence directory drops an entry, caches may still hold the blocks it tracked. This block takes those dropped entries and turns each one into invalidation messages. A dropped entry is either a per-block entry, which carries a vector with one bit per core that shares the block, or a region entry, which carries one owning core and a vector with one bit per block of the region that the owner holds. Dropped entries wait in a small in-order queue, so the directory can keep serving requests. The sequencer then works on one entry at a time and sends at most one message per cycle on a valid/ready output.

A per-block entry with exactly one sharer gets a different path. Before any invalidate goes out, the sequencer asks the directory whether a region entry covers the block's region. If that region entry exists and its owner is the lone sharer, the sequencer sets the block's present bit in the region entry instead. The cached copy then stays valid and no message is sent. If the lookup misses, or the owner is a different core, the block falls back to a plain invalidate to its sharer.

A block address is a region tag followed by a 4-bit block index in the low bits. A region entry supplies its tag in the upper bits of the address input, and its low index bits are ignored.

Top module: `evict_inval_seq`

## Requirements
- R1: A per-block entry whose sharer vector has two or more bits set produces one invalidate per set bit. Each invalidate goes to the core with that bit's index and carries the entry's full block address.
- R2: A region entry produces one invalidate per set present bit, always addressed to the owner core. The message address is the region tag (address bits 23:4) concatenated with the 4-bit index of the present bit.
- R3: The messages for one entry leave in ascending bit-index order, and a message is consumed only in a cycle where both inv_valid and inv_ready are high. While inv_ready is low, inv_valid, inv_core and inv_addr hold steady.
- R4: Up to DEPTH entries wait in the queue beyond the one being worked on. ev_ready is low while the queue is full. Entries are handled strictly in arrival order.
- R5: A directory lookup is requested only for a per-block entry with exactly one sharer bit set. The request is a single-cycle lk_req_valid pulse carrying the block's region tag (address bits 23:4). Region entries and per-block entries with several sharers never cause a lookup.
- R6: If the lookup response reports a hit whose owner equals the lone sharer, the sequencer pulses ps_valid for exactly one cycle with the region tag and the block index (address bits 3:0). No invalidate is sent for that entry.
- R7: If the lookup response reports a miss, or a hit owned by a different core, exactly one invalidate goes to the lone sharer with the block address.
- R8: An entry whose sharer or present vector is all zero produces no message, no lookup and no present-bit update.
- R9: After reset, ev_ready is high and inv_valid, lk_req_valid and ps_valid are low.
- R10: In any cycle, at most one of inv_valid, lk_req_valid and ps_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | A dropped directory entry is offered |
| ev_ready | output | 1 | The queue can accept an entry |
| ev_is_region | input | 1 | 1: region entry, 0: per-block entry |
| ev_addr | input | 24 | Block address; for a region entry only bits 23:4 (tag) are used |
| ev_vec | input | 16 | Sharer vector (per-block entry) or present vector (region entry) |
| ev_owner | input | 4 | Owner core of a region entry |
| lk_req_valid | output | 1 | Region lookup request pulse |
| lk_req_tag | output | 20 | Region tag to look up |
| lk_rsp_valid | input | 1 | Lookup response present |
| lk_rsp_hit | input | 1 | A region entry exists for the tag |
| lk_rsp_owner | input | 4 | Owner of the found region entry |
| ps_valid | output | 1 | Set a present bit in a region entry |
| ps_tag | output | 20 | Region tag of the entry to update |
| ps_idx | output | 4 | Block index whose present bit is set |
| inv_valid | output | 1 | Invalidate message valid |
| inv_ready | input | 1 | Downstream accepts the message |
| inv_core | output | 4 | Target core |
| inv_addr | output | 24 | Block address to invalidate |

## Verification
The hardest situations to reach are the merge decisions. They depend on a response that arrives a variable number of cycles after the request and that the directory alone supplies. The bench models the directory with a responder that answers each lookup after a chosen delay. The answer is a hit with a matching owner, a hit with a foreign owner, or a miss, which drives each branch of the merge decision in turn. Queue-full ordering is reached by holding inv_ready low so that the first entry stalls mid-issue while later entries pile up behind it.

// File: rtl/evseq_pkg.sv
package evseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ISSUE = 3'd1,
        PH_LOOK  = 3'd2,
        PH_WAIT  = 3'd3,
        PH_MERGE = 3'd4
    } seq_phase_e;

endpackage

// File: rtl/evseq_fifo.sv
module evseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          do_push, do_pop;

    assign full     = (st_q.cnt == CW'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign pop_data = mem_q[st_q.rp];
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + PW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = bump(st_q.wp);
        if (do_pop)  st_d.rp = bump(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= push_data;
    end
endmodule

// File: rtl/evseq_lowpick.sv
module evseq_lowpick #(
    parameter int W = 16
) (
    input  logic [W-1:0]         vec,
    output logic                 any,
    output logic [$clog2(W)-1:0] idx,
    output logic [W-1:0]         rest
);
    localparam int IW = $clog2(W);

    logic [W-1:0] below;
    logic [W-1:0] first;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            if (g == 0) begin : g_lsb
                assign below[g] = 1'b0;
            end else begin : g_up
                assign below[g] = below[g-1] | vec[g-1];
            end
            assign first[g] = vec[g] & ~below[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx = IW'(i);
        end
    end

    assign any  = |vec;
    assign rest = vec & ~first;
endmodule

// File: rtl/evseq_ctrl.sv
module evseq_ctrl
    import evseq_pkg::*;
#(
    parameter int NCORE  = 16,
    parameter int NBLK   = 16,
    parameter int RTAG_W = 20
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   q_empty,
    output logic                                   q_pop,
    input  logic                                   e_is_region,
    input  logic [RTAG_W+$clog2(NBLK)-1:0]         e_addr,
    input  logic [((NCORE>NBLK)?NCORE:NBLK)-1:0]   e_vec,
    input  logic [$clog2(NCORE)-1:0]               e_owner,
    output logic                                   lk_req_valid,
    output logic [RTAG_W-1:0]                      lk_req_tag,
    input  logic                                   lk_rsp_valid,
    input  logic                                   lk_rsp_hit,
    input  logic [$clog2(NCORE)-1:0]               lk_rsp_owner,
    output logic                                   ps_valid,
    output logic [RTAG_W-1:0]                      ps_tag,
    output logic [$clog2(NBLK)-1:0]                ps_idx,
    output logic                                   inv_valid,
    input  logic                                   inv_ready,
    output logic [$clog2(NCORE)-1:0]               inv_core,
    output logic [RTAG_W+$clog2(NBLK)-1:0]         inv_addr
);
    localparam int IDX_W   = $clog2(NBLK);
    localparam int CORE_W  = $clog2(NCORE);
    localparam int BADDR_W = RTAG_W + IDX_W;
    localparam int VEC_W   = (NCORE > NBLK) ? NCORE : NBLK;
    localparam int VIDX_W  = $clog2(VEC_W);

    typedef struct packed {
        seq_phase_e           ph;
        logic                 is_region;
        logic [BADDR_W-1:0]   addr;
        logic [VEC_W-1:0]     vec;
        logic [CORE_W-1:0]    owner;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [VEC_W-1:0]  core_mask, blk_mask;
    logic [VEC_W-1:0]  in_vec;
    logic              pk_any;
    logic [VIDX_W-1:0] pk_idx;
    logic [VEC_W-1:0]  pk_rest;

    genvar g;
    generate
        for (g = 0; g < VEC_W; g++) begin : g_mask
            assign core_mask[g] = (g < NCORE);
            assign blk_mask[g]  = (g < NBLK);
        end
    endgenerate

    assign in_vec = e_vec & (e_is_region ? blk_mask : core_mask);

    evseq_lowpick #(.W(VEC_W)) u_pick (
        .vec  (st_q.vec),
        .any  (pk_any),
        .idx  (pk_idx),
        .rest (pk_rest)
    );

    always_comb begin
        st_d         = st_q;
        q_pop        = 1'b0;
        lk_req_valid = 1'b0;
        ps_valid     = 1'b0;
        inv_valid    = 1'b0;

        case (st_q.ph)
            PH_IDLE: begin
                if (!q_empty) begin
                    q_pop          = 1'b1;
                    st_d.is_region = e_is_region;
                    st_d.addr      = e_addr;
                    st_d.vec       = in_vec;
                    st_d.owner     = e_owner;
                    if (in_vec == '0)
                        st_d.ph = PH_IDLE;
                    else if (!e_is_region && $onehot(in_vec))
                        st_d.ph = PH_LOOK;
                    else
                        st_d.ph = PH_ISSUE;
                end
            end
            PH_LOOK: begin
                lk_req_valid = 1'b1;
                st_d.ph      = PH_WAIT;
            end
            PH_WAIT: begin
                if (lk_rsp_valid) begin
                    if (lk_rsp_hit && (lk_rsp_owner == pk_idx[CORE_W-1:0]))
                        st_d.ph = PH_MERGE;
                    else
                        st_d.ph = PH_ISSUE;
                end
            end
            PH_MERGE: begin
                ps_valid = 1'b1;
                st_d.vec = '0;
                st_d.ph  = PH_IDLE;
            end
            PH_ISSUE: begin
                inv_valid = pk_any;
                if (inv_ready || !pk_any) begin
                    st_d.vec = pk_rest;
                    if (pk_rest == '0) st_d.ph = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lk_req_tag = st_q.addr[BADDR_W-1:IDX_W];
    assign ps_tag     = st_q.addr[BADDR_W-1:IDX_W];
    assign ps_idx     = st_q.addr[IDX_W-1:0];
    assign inv_core   = st_q.is_region ? st_q.owner : pk_idx[CORE_W-1:0];
    assign inv_addr   = st_q.is_region ? {st_q.addr[BADDR_W-1:IDX_W], pk_idx[IDX_W-1:0]}
                                       : st_q.addr;
endmodule

// File: rtl/evict_inval_seq.sv
module evict_inval_seq #(
    parameter int NCORE  = 16,
    parameter int NBLK   = 16,
    parameter int RTAG_W = 20,
    parameter int DEPTH  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ev_valid,
    output logic                                 ev_ready,
    input  logic                                 ev_is_region,
    input  logic [RTAG_W+$clog2(NBLK)-1:0]       ev_addr,
    input  logic [((NCORE>NBLK)?NCORE:NBLK)-1:0] ev_vec,
    input  logic [$clog2(NCORE)-1:0]             ev_owner,
    output logic                                 lk_req_valid,
    output logic [RTAG_W-1:0]                    lk_req_tag,
    input  logic                                 lk_rsp_valid,
    input  logic                                 lk_rsp_hit,
    input  logic [$clog2(NCORE)-1:0]             lk_rsp_owner,
    output logic                                 ps_valid,
    output logic [RTAG_W-1:0]                    ps_tag,
    output logic [$clog2(NBLK)-1:0]              ps_idx,
    output logic                                 inv_valid,
    input  logic                                 inv_ready,
    output logic [$clog2(NCORE)-1:0]             inv_core,
    output logic [RTAG_W+$clog2(NBLK)-1:0]       inv_addr
);
    localparam int IDX_W   = $clog2(NBLK);
    localparam int CORE_W  = $clog2(NCORE);
    localparam int BADDR_W = RTAG_W + IDX_W;
    localparam int VEC_W   = (NCORE > NBLK) ? NCORE : NBLK;

    typedef struct packed {
        logic               is_region;
        logic [CORE_W-1:0]  owner;
        logic [VEC_W-1:0]   vec;
        logic [BADDR_W-1:0] addr;
    } evict_ent_t;

    localparam int ENT_W = $bits(evict_ent_t);

    evict_ent_t in_ent, out_ent;
    logic       q_full, q_empty, q_pop;

    assign in_ent.is_region = ev_is_region;
    assign in_ent.owner     = ev_owner;
    assign in_ent.vec       = ev_vec;
    assign in_ent.addr      = ev_addr;
    assign ev_ready         = !q_full;

    evseq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ev_valid),
        .push_data (in_ent),
        .pop       (q_pop),
        .pop_data  (out_ent),
        .full      (q_full),
        .empty     (q_empty)
    );

    evseq_ctrl #(.NCORE(NCORE), .NBLK(NBLK), .RTAG_W(RTAG_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_empty      (q_empty),
        .q_pop        (q_pop),
        .e_is_region  (out_ent.is_region),
        .e_addr       (out_ent.addr),
        .e_vec        (out_ent.vec),
        .e_owner      (out_ent.owner),
        .lk_req_valid (lk_req_valid),
        .lk_req_tag   (lk_req_tag),
        .lk_rsp_valid (lk_rsp_valid),
        .lk_rsp_hit   (lk_rsp_hit),
        .lk_rsp_owner (lk_rsp_owner),
        .ps_valid     (ps_valid),
        .ps_tag       (ps_tag),
        .ps_idx       (ps_idx),
        .inv_valid    (inv_valid),
        .inv_ready    (inv_ready),
        .inv_core     (inv_core),
        .inv_addr     (inv_addr)
    );
endmodule

// File: rtl/evict_inval_seq_chk.sv
module evict_inval_seq_chk #(
    parameter int CORE_W  = 4,
    parameter int BADDR_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inv_valid,
    input logic               inv_ready,
    input logic [CORE_W-1:0]  inv_core,
    input logic [BADDR_W-1:0] inv_addr,
    input logic               lk_req_valid,
    input logic               lk_rsp_valid,
    input logic               ps_valid
);
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({inv_valid, lk_req_valid, ps_valid}) <= 1); // R10

    AST_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_core) && $stable(inv_addr))); // R3

    AST_LK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_valid |=> !lk_req_valid); // R5

    AST_PS_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        ps_valid |-> $past(lk_rsp_valid)); // R6

    AST_PS_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
        ps_valid |=> (!inv_valid && !ps_valid)); // R6
endmodule

bind evict_inval_seq evict_inval_seq_chk #(.CORE_W(CORE_W), .BADDR_W(BADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inv_valid    (inv_valid),
    .inv_ready    (inv_ready),
    .inv_core     (inv_core),
    .inv_addr     (inv_addr),
    .lk_req_valid (lk_req_valid),
    .lk_rsp_valid (lk_rsp_valid),
    .ps_valid     (ps_valid)
);

// File: tb/evict_inval_seq_bench.sv
module evict_inval_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic        ev_is_region = 1'b0;
    logic [23:0] ev_addr = '0;
    logic [15:0] ev_vec = '0;
    logic [3:0]  ev_owner = '0;
    logic        lk_req_valid;
    logic [19:0] lk_req_tag;
    logic        lk_rsp_valid = 1'b0;
    logic        lk_rsp_hit = 1'b0;
    logic [3:0]  lk_rsp_owner = '0;
    logic        ps_valid;
    logic [19:0] ps_tag;
    logic [3:0]  ps_idx;
    logic        inv_valid;
    logic        inv_ready = 1'b1;
    logic [3:0]  inv_core;
    logic [23:0] inv_addr;

    always #2 clk = ~clk;

    evict_inval_seq u_evict_inval_seq (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_is_region(ev_is_region),
        .ev_addr(ev_addr), .ev_vec(ev_vec), .ev_owner(ev_owner),
        .lk_req_valid(lk_req_valid), .lk_req_tag(lk_req_tag),
        .lk_rsp_valid(lk_rsp_valid), .lk_rsp_hit(lk_rsp_hit), .lk_rsp_owner(lk_rsp_owner),
        .ps_valid(ps_valid), .ps_tag(ps_tag), .ps_idx(ps_idx),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_core(inv_core), .inv_addr(inv_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [3:0]  log_core [0:255];
    logic [23:0] log_addr [0:255];
    int          n_inv = 0;
    logic [19:0] log_lk   [0:255];
    int          n_lk = 0;
    logic [19:0] log_pst  [0:255];
    logic [3:0]  log_psi  [0:255];
    int          n_ps = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (inv_valid && inv_ready && n_inv < 256) begin
                log_core[n_inv] = inv_core; log_addr[n_inv] = inv_addr; n_inv++;
            end
            if (lk_req_valid && n_lk < 256) begin log_lk[n_lk] = lk_req_tag; n_lk++; end
            if (ps_valid && n_ps < 256) begin
                log_pst[n_ps] = ps_tag; log_psi[n_ps] = ps_idx; n_ps++;
            end
        end
    end

    // directory model: answers each lookup after rsp_delay cycles
    int  rsp_delay = 0;
    bit  pend = 0;
    int  pcnt = 0;
    always @(negedge clk) begin
        lk_rsp_valid <= 1'b0;
        if (pend) begin
            if (pcnt == 0) begin lk_rsp_valid <= 1'b1; pend <= 0; end
            else pcnt <= pcnt - 1;
        end
        if (lk_req_valid) begin pend <= 1; pcnt <= rsp_delay; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input bit reg_e, input logic [23:0] a, input logic [15:0] v, input logic [3:0] own);
        @(posedge clk); #1;
        ev_valid = 1'b1; ev_is_region = reg_e; ev_addr = a; ev_vec = v; ev_owner = own;
        while (1) begin
            @(negedge clk);
            if (ev_ready) break;
            @(posedge clk);
        end
        @(posedge clk); #1;
        ev_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(ev_ready == 1'b1, "R9 ev_ready", 32'(ev_ready), 1);
        chk({inv_valid, lk_req_valid, ps_valid} == 3'b000, "R9 outputs idle",
            32'({inv_valid, lk_req_valid, ps_valid}), 0);
    endtask

    task automatic t_block_multi();
        int b = n_inv; int l = n_lk;
        push(1'b0, 24'hABC123, 16'h8022, 4'd0);
        settle(20);
        chk(n_inv - b == 3, "R1 block inval count", 32'(n_inv - b), 3);
        chk(log_core[b] == 4'd1 && log_core[b+1] == 4'd5 && log_core[b+2] == 4'd15,
            "R3 ascending sharers", {log_core[b], log_core[b+1], log_core[b+2]}, 32'h15f);
        chk(log_addr[b] == 24'hABC123 && log_addr[b+2] == 24'hABC123, "R1 block addr",
            32'(log_addr[b+2]), 32'hABC123);
        chk(n_lk == l, "R5 no lookup for multi-sharer", 32'(n_lk - l), 0);
    endtask

    task automatic t_region();
        int b = n_inv; int l = n_lk;
        push(1'b1, 24'h12345F, 16'h8009, 4'd7);
        settle(20);
        chk(n_inv - b == 3, "R2 region inval count", 32'(n_inv - b), 3);
        chk(log_core[b] == 4'd7 && log_core[b+1] == 4'd7 && log_core[b+2] == 4'd7,
            "R2 owner target", 32'(log_core[b+1]), 7);
        chk(log_addr[b] == 24'h123450 && log_addr[b+1] == 24'h123453 && log_addr[b+2] == 24'h12345F,
            "R2 tag+index addr", 32'(log_addr[b+1]), 32'h123453);
        chk(n_lk == l, "R5 no lookup for region", 32'(n_lk - l), 0);
    endtask

    task automatic t_backpressure();
        int b = n_inv;
        inv_ready = 1'b0;
        push(1'b1, 24'h0AA000, 16'h0F00, 4'd3);
        settle(5);
        @(negedge clk);
        chk(inv_valid == 1'b1 && inv_core == 4'd3 && inv_addr == 24'h0AA008,
            "R3 stalled head held", 32'(inv_addr), 32'h0AA008);
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1;
            inv_ready = (i % 3 != 0);
        end
        inv_ready = 1'b1;
        settle(10);
        chk(n_inv - b == 4, "R3 count under stalls", 32'(n_inv - b), 4);
        chk(log_addr[b] == 24'h0AA008 && log_addr[b+1] == 24'h0AA009 &&
            log_addr[b+2] == 24'h0AA00A && log_addr[b+3] == 24'h0AA00B,
            "R3 order under stalls", 32'(log_addr[b+3]), 32'h0AA00B);
    endtask

    task automatic t_merge_hit();
        int b = n_inv; int l = n_lk; int p = n_ps;
        rsp_delay = 3; lk_rsp_hit = 1'b1; lk_rsp_owner = 4'd4;
        push(1'b0, 24'h5678A6, 16'h0010, 4'd0);
        settle(20);
        chk(n_lk - l == 1 && log_lk[l] == 20'h5678A, "R5 lookup tag", 32'(log_lk[l]), 32'h5678A);
        chk(n_ps - p == 1 && log_pst[p] == 20'h5678A && log_psi[p] == 4'd6,
            "R6 present-bit set", {log_pst[p], log_psi[p]}, 32'h5678A6);
        chk(n_inv == b, "R6 no invalidate on merge", 32'(n_inv - b), 0);
    endtask

    task automatic t_merge_foreign();
        int b = n_inv; int p = n_ps;
        rsp_delay = 0; lk_rsp_hit = 1'b1; lk_rsp_owner = 4'd9;
        push(1'b0, 24'h111112, 16'h0010, 4'd0);
        settle(20);
        chk(n_inv - b == 1 && log_core[b] == 4'd4 && log_addr[b] == 24'h111112,
            "R7 foreign owner falls back", 32'(log_core[b]), 4);
        chk(n_ps == p, "R7 no present-bit set", 32'(n_ps - p), 0);
    endtask

    task automatic t_merge_miss();
        int b = n_inv; int p = n_ps;
        rsp_delay = 5; lk_rsp_hit = 1'b0; lk_rsp_owner = 4'd2;
        push(1'b0, 24'h222227, 16'h0004, 4'd0);
        settle(20);
        chk(n_inv - b == 1 && log_core[b] == 4'd2 && log_addr[b] == 24'h222227,
            "R7 miss falls back", 32'(log_addr[b]), 32'h222227);
        chk(n_ps == p, "R7 miss no present-bit", 32'(n_ps - p), 0);
    endtask

    task automatic t_region_single();
        int b = n_inv; int l = n_lk;
        push(1'b1, 24'h333330, 16'h0020, 4'd11);
        settle(15);
        chk(n_lk == l, "R5 region single bit no lookup", 32'(n_lk - l), 0);
        chk(n_inv - b == 1 && log_core[b] == 4'd11 && log_addr[b] == 24'h333335,
            "R2 single present bit", 32'(log_addr[b]), 32'h333335);
    endtask

    task automatic t_empty();
        int b = n_inv; int l = n_lk; int p = n_ps;
        push(1'b0, 24'h444444, 16'h0000, 4'd0);
        push(1'b1, 24'h555550, 16'h0000, 4'd5);
        settle(15);
        chk(n_inv == b && n_lk == l && n_ps == p, "R8 empty vectors silent",
            32'((n_inv - b) + (n_lk - l) + (n_ps - p)), 0);
    endtask

    task automatic t_full();
        int b = n_inv;
        inv_ready = 1'b0;
        for (int i = 0; i < 5; i++) begin
            push(1'b1, {20'(24'h60000 + i), 4'h0}, 16'(1 << i), 4'(i + 1));
        end
        settle(3);
        @(negedge clk);
        chk(ev_ready == 1'b0, "R4 full drops ready", 32'(ev_ready), 0);
        @(posedge clk); #1;
        inv_ready = 1'b1;
        settle(30);
        chk(n_inv - b == 5, "R4 all queued drained", 32'(n_inv - b), 5);
        for (int i = 0; i < 5; i++) begin
            chk(log_core[b+i] == 4'(i + 1) && log_addr[b+i] == {20'(24'h60000 + i), 4'(i)},
                "R4 arrival order", 32'(log_addr[b+i]), {20'(24'h60000 + i), 4'(i)});
        end
        chk(ev_ready == 1'b1, "R4 ready after drain", 32'(ev_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_block_multi();
        t_region();
        t_backpressure();
        t_merge_hit();
        t_merge_foreign();
        t_merge_miss();
        t_region_single();
        t_empty();
        t_full();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule